// File: doc/BRIEF.md
# Programmable asynchronous frame transmitter

This block turns one parallel character per request into an asynchronous serial frame on a single line output. A character enters through a valid/ready handshake and waits in a one-entry holding stage. The shift stage then takes it together with the current line-control settings, which set the word length (five to eight bits), parity on or off, even or odd parity, forced (sticky) parity for multidrop address marking, and one or two stop bits. An external divisor supplies a bit-rate enable tick, and every serial bit lasts a fixed number of those ticks.

A break control pulls the line low for as long as it is set. It acts only on the output pin: the shift stage keeps counting and shifting underneath, so the frame timing is the same as it would be without the break. An empty flag reports when the holding stage has no character and the shift stage has finished its last stop bit. When a second character waits in the holding stage, it is loaded at the edge where the current frame ends, so there is no idle bit between the two frames.

Top module: `frame_tx_top`

## Requirements
- R1: The line idles at 1 after reset and between frames. Every frame begins with one start bit at 0 at frame position 0.
- R2: The word length is set by `lc_wlen` (2'b00 = 5, 2'b01 = 6, 2'b10 = 7, 2'b11 = 8 data bits). Data bits occupy frame positions 1..n, least significant bit first.
- R3: Stop bits are 1. There is one stop bit when `lc_stop2` = 0 and two when `lc_stop2` = 1. They follow the parity bit, or the last data bit when parity is off.
- R4: When `lc_par_en` = 1 and `lc_sticky` = 0, a parity bit sits at position n+1. With `lc_even` = 1 it is the XOR of the n data bits, which gives even parity. With `lc_even` = 0 it is the inverse of that XOR.
- R5: When `lc_par_en` = 1 and `lc_sticky` = 1, the parity bit is the complement of `lc_even`, whatever the data.
- R6: When `lc_par_en` = 0, no parity bit is sent and `lc_sticky` has no effect on the frame.
- R7: While `lc_break` = 1, `txd` is 0. The shift stage keeps running, so the bits after the break is cleared appear at their normal times.
- R8: Each bit lasts TICKS_PER_BIT (default 16) cycles in which `tick` = 1. Without ticks the frame does not advance.
- R9: `tx_empty` is 1 only when no character is held and the shift stage is idle. It goes to 0 after a character is accepted and returns to 1 at the edge that ends the last stop bit.
- R10: `in_ready` is 1 exactly when the holding stage is empty. A character accepted while a frame is being sent is loaded at the edge that ends that frame, with no idle gap.
- R11: The line-control settings are captured when a character is loaded into the shift stage. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Bit-rate enable from the external divisor |
| lc_wlen | input | 2 | Word length code (5 + code data bits) |
| lc_par_en | input | 1 | Parity bit enable |
| lc_even | input | 1 | Even-parity select |
| lc_sticky | input | 1 | Forced parity select |
| lc_stop2 | input | 1 | Two stop bits when 1 |
| lc_break | input | 1 | Hold the line at 0 |
| in_data | input | 8 | Character to send (low n bits used) |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Holding stage can accept |
| txd | output | 1 | Serial line output |
| tx_empty | output | 1 | Holding and shift stages both idle |

## Verification
A character accepted at edge E0 is loaded at edge E0+1. Frame bit k is on the line from edge E0+1+16k until edge E0+1+16(k+1), and `tx_empty` rises exactly at edge E0+1+16L for a frame of L bits. The bench counts edges from the handshake and samples every bit at the falling clock edge in the middle of its slot. It reads `tx_empty` on both sides of the closing edge, so a frame one cycle too long or too short is reported. For the back-to-back, stalled-tick and break cases, the bench moves its sampling origin by the known number of edges rather than searching for the start bit.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

    localparam int MAX_DATA = 8;
    localparam int MIN_DATA = 5;
    localparam int FRAME_W  = MAX_DATA + 4;
    localparam int IDX_W    = $clog2(FRAME_W);

    typedef struct packed {
        logic [1:0] wlen;
        logic       par_en;
        logic       even_sel;
        logic       sticky;
        logic       stop2;
    } line_ctl_t;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;
        logic [IDX_W-1:0]   last;
    } frame_t;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_SEND = 1'b1
    } shift_state_t;

    function automatic logic [IDX_W-1:0] data_count(input logic [1:0] wlen);
        return IDX_W'(wlen) + IDX_W'(MIN_DATA);
    endfunction

    function automatic logic parity_of(input logic [MAX_DATA-1:0] d,
                                       input line_ctl_t lc);
        logic acc;
        acc = 1'b0;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < int'(data_count(lc.wlen)))
                acc = acc ^ d[i];
        end
        if (lc.sticky)
            return ~lc.even_sel;
        return acc ^ ~lc.even_sel;
    endfunction

endpackage

// File: rtl/ftx_hold_stage.sv
module ftx_hold_stage
    import frame_tx_pkg::*;
#(
    parameter int W = MAX_DATA
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] in_data,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data_q
);
    logic accept;

    assign in_ready = !full;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            full   <= 1'b0;
            data_q <= '0;
        end else if (accept) begin
            full   <= 1'b1;
            data_q <= in_data;
        end else if (take) begin
            full   <= 1'b0;
        end
    end
endmodule

// File: rtl/ftx_frame_builder.sv
module ftx_frame_builder
    import frame_tx_pkg::*;
(
    input  logic [MAX_DATA-1:0] data,
    input  line_ctl_t           lc,
    output frame_t              frame
);
    logic [IDX_W-1:0]   n_bits;
    logic [IDX_W-1:0]   par_pos;
    logic               par_bit;
    logic [FRAME_W-1:0] bits_w;

    assign n_bits  = data_count(lc.wlen);
    assign par_pos = n_bits + IDX_W'(1);
    assign par_bit = parity_of(data, lc);

    for (genvar j = 0; j < FRAME_W; j++) begin : g_pos
        localparam logic [IDX_W-1:0] POS = IDX_W'(j);
        if (j == 0) begin : g_start
            assign bits_w[j] = 1'b0;
        end else if (j <= MAX_DATA) begin : g_data
            assign bits_w[j] = (POS <= n_bits)              ? data[j-1] :
                               (lc.par_en && POS == par_pos) ? par_bit   : 1'b1;
        end else begin : g_tail
            assign bits_w[j] = (lc.par_en && POS == par_pos) ? par_bit : 1'b1;
        end
    end

    assign frame.bits = bits_w;
    assign frame.last = n_bits + IDX_W'(lc.par_en) + IDX_W'(lc.stop2) + IDX_W'(1);
endmodule

// File: rtl/ftx_bit_timer.sv
module ftx_bit_timer #(
    parameter int TICKS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    input  logic tick,
    output logic bit_end
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    assign bit_end = run && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (run && tick)
            cnt <= bit_end ? '0 : cnt + CW'(1);
    end
endmodule

// File: rtl/ftx_shifter.sv
module ftx_shifter
    import frame_tx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load_req,
    input  frame_t frame_in,
    input  logic   bit_end,
    output logic   take,
    output logic   busy,
    output logic   line_out
);
    shift_state_t     state;
    frame_t           frame_q;
    logic [IDX_W-1:0] idx;
    logic             last_bit;

    assign busy     = (state == SH_SEND);
    assign last_bit = busy && bit_end && (idx == frame_q.last);
    assign take     = load_req && (!busy || last_bit);
    assign line_out = busy ? frame_q.bits[idx] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SH_IDLE;
            frame_q <= '0;
            idx     <= '0;
        end else if (take) begin
            state   <= SH_SEND;
            frame_q <= frame_in;
            idx     <= '0;
        end else if (last_bit) begin
            state   <= SH_IDLE;
            idx     <= '0;
        end else if (busy && bit_end) begin
            idx     <= idx + IDX_W'(1);
        end
    end
endmodule

// File: rtl/frame_tx_top.sv
module frame_tx_top
    import frame_tx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [1:0]          lc_wlen,
    input  logic                lc_par_en,
    input  logic                lc_even,
    input  logic                lc_sticky,
    input  logic                lc_stop2,
    input  logic                lc_break,
    input  logic [MAX_DATA-1:0] in_data,
    input  logic                in_valid,
    output logic                in_ready,
    output logic                txd,
    output logic                tx_empty
);
    line_ctl_t           lc;
    frame_t              frame_next;
    logic                hold_full;
    logic [MAX_DATA-1:0] hold_data;
    logic                take;
    logic                shift_busy;
    logic                bit_end;
    logic                line_raw;

    assign lc = '{wlen: lc_wlen, par_en: lc_par_en, even_sel: lc_even,
                  sticky: lc_sticky, stop2: lc_stop2};

    ftx_hold_stage #(.W(MAX_DATA)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .in_data  (in_data),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .take     (take),
        .full     (hold_full),
        .data_q   (hold_data)
    );

    ftx_frame_builder u_build (
        .data  (hold_data),
        .lc    (lc),
        .frame (frame_next)
    );

    ftx_bit_timer #(.TICKS(TICKS_PER_BIT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (take),
        .run     (shift_busy),
        .tick    (tick),
        .bit_end (bit_end)
    );

    ftx_shifter u_shift (
        .clk      (clk),
        .rst      (rst),
        .load_req (hold_full),
        .frame_in (frame_next),
        .bit_end  (bit_end),
        .take     (take),
        .busy     (shift_busy),
        .line_out (line_raw)
    );

    assign txd      = lc_break ? 1'b0 : line_raw;
    assign tx_empty = !hold_full && !shift_busy;
endmodule

// File: rtl/frame_tx_checker.sv
module frame_tx_checker (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic lc_break,
    input logic in_valid,
    input logic in_ready,
    input logic txd,
    input logic tx_empty,
    input logic shift_busy
);
    a_r7_break_forces_low: assert property (@(posedge clk) disable iff (rst)
        lc_break |-> !txd);

    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (rst)
        (tx_empty && !lc_break) |-> txd);

    a_r10_accept_fills_hold: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    a_r9_accept_clears_empty: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !tx_empty);

    a_r9_empty_means_hold_free: assert property (@(posedge clk) disable iff (rst)
        tx_empty |-> in_ready);

    a_r8_no_tick_no_advance: assert property (@(posedge clk) disable iff (rst)
        (shift_busy && !tick && !lc_break) |=> (lc_break || $stable(txd)));
endmodule

bind frame_tx_top frame_tx_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .lc_break   (lc_break),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .txd        (txd),
    .tx_empty   (tx_empty),
    .shift_busy (shift_busy)
);

// File: tb/tb_frame_tx_top.sv
module tb_frame_tx_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick;
    logic [1:0] lc_wlen;
    logic       lc_par_en, lc_even, lc_sticky, lc_stop2, lc_break;
    logic [7:0] in_data;
    logic       in_valid;
    logic       in_ready, txd, tx_empty;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    frame_tx_top dut (
        .clk(clk), .rst(rst), .tick(tick),
        .lc_wlen(lc_wlen), .lc_par_en(lc_par_en), .lc_even(lc_even),
        .lc_sticky(lc_sticky), .lc_stop2(lc_stop2), .lc_break(lc_break),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .txd(txd), .tx_empty(tx_empty)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic [1:0] wl,
                                              input logic pe, input logic ev, input logic st);
        int n;
        logic [11:0] f;
        logic par;
        n = 5 + int'(wl);
        f = '1;
        f[0] = 1'b0;
        par = 1'b0;
        for (int i = 0; i < n; i++) begin
            f[1+i] = d[i];
            par = par ^ d[i];
        end
        if (pe) f[n+1] = st ? ~ev : (ev ? par : ~par);
        return f;
    endfunction

    function automatic int exp_len(input logic [1:0] wl, input logic pe, input logic s2);
        return 2 + 5 + int'(wl) + int'(pe) + int'(s2);
    endfunction

    // Called at a negedge; returns at the negedge after the accepting edge.
    task automatic send(input logic [7:0] d);
        in_data  = d;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Samples bits k0..L-1 mid-slot, then checks the closing edge of the frame.
    task automatic check_frame(input logic [11:0] f, input int L, input int k0,
                               input int w0, input bit idle_end, input string req);
        int w;
        int first_stop;
        string tag;
        w = w0;
        first_stop = L - 1 - (lc_stop2 ? 1 : 0);
        for (int k = k0; k < L; k++) begin
            repeat (w) @(posedge clk);
            @(negedge clk);
            tag = (k == 0) ? "R1" : (k >= first_stop) ? "R3" : req;
            chk(tag, $sformatf("frame bit %0d", k), int'(txd), int'(f[k]));
            w = 16;
        end
        repeat (7) @(posedge clk);
        @(negedge clk);
        chk("R9", "empty before last edge", int'(tx_empty), 0);
        @(posedge clk);
        @(negedge clk);
        if (idle_end) begin
            chk("R9", "empty after last stop", int'(tx_empty), 1);
            chk("R1", "idle line after frame", int'(txd), 1);
        end else begin
            chk("R10", "next frame pending", int'(tx_empty), 0);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : stim
        logic [11:0] fa, fb;
        int la, lb;
        string tag;
        rst = 1'b1; tick = 1'b1; lc_wlen = 2'b11; lc_par_en = 1'b0; lc_even = 1'b0;
        lc_sticky = 1'b0; lc_stop2 = 1'b0; lc_break = 1'b0; in_data = '0; in_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "reset line level", int'(txd), 1);
        chk("R9", "reset empty", int'(tx_empty), 1);
        chk("R10", "reset ready", int'(in_ready), 1);

        // Sweep of every line-control setting, two characters each (R2..R6)
        for (int cfg = 0; cfg < 64; cfg++) begin
            lc_wlen   = cfg[1:0];
            lc_par_en = cfg[2];
            lc_even   = cfg[3];
            lc_sticky = cfg[4];
            lc_stop2  = cfg[5];
            tag = (lc_par_en && lc_sticky) ? "R5" : lc_par_en ? "R4" :
                  lc_sticky ? "R6" : "R2";
            for (int rep = 0; rep < 2; rep++) begin
                logic [7:0] d;
                d = 8'((cfg * 37 + 5) & 255);
                if (rep == 1) d = ~d;
                fa = exp_frame(d, lc_wlen, lc_par_en, lc_even, lc_sticky);
                la = exp_len(lc_wlen, lc_par_en, lc_stop2);
                send(d);
                chk("R10", "ready drops after accept", int'(in_ready), 0);
                @(negedge clk);
                chk("R10", "ready back after load", int'(in_ready), 1);
                check_frame(fa, la, 0, 8, 1'b1, tag);
            end
        end

        // R10: back-to-back characters, no idle gap
        lc_wlen = 2'b11; lc_par_en = 1'b1; lc_even = 1'b1; lc_sticky = 1'b0; lc_stop2 = 1'b0;
        fa = exp_frame(8'hC3, lc_wlen, 1'b1, 1'b1, 1'b0);
        fb = exp_frame(8'h3D, lc_wlen, 1'b1, 1'b1, 1'b0);
        la = exp_len(lc_wlen, 1'b1, 1'b0);
        send(8'hC3);
        @(negedge clk);
        send(8'h3D);
        chk("R10", "ready low while second held", int'(in_ready), 0);
        check_frame(fa, la, 0, 7, 1'b0, "R10");
        check_frame(fb, la, 0, 8, 1'b1, "R10");

        // R7: break during a frame; later bits keep their slots
        lc_par_en = 1'b0; lc_stop2 = 1'b0;
        fa = exp_frame(8'hFF, lc_wlen, 1'b0, 1'b0, 1'b0);
        la = exp_len(lc_wlen, 1'b0, 1'b0);
        send(8'hFF);
        @(negedge clk);
        lc_break = 1'b1;
        #1 chk("R7", "break takes the line", int'(txd), 0);
        repeat (24) @(posedge clk);
        @(negedge clk);
        chk("R7", "line low during data bit", int'(txd), 0);
        chk("R7", "busy during break", int'(tx_empty), 0);
        lc_break = 1'b0;
        check_frame(fa, la, 2, 16, 1'b1, "R7");

        // R7: break while idle
        lc_break = 1'b1;
        @(negedge clk);
        chk("R7", "idle break line", int'(txd), 0);
        chk("R7", "idle break empty", int'(tx_empty), 1);
        lc_break = 1'b0;
        @(negedge clk);
        chk("R7", "line after break release", int'(txd), 1);

        // R8: no ticks, no progress
        lc_wlen = 2'b10; lc_par_en = 1'b1; lc_even = 1'b0; lc_stop2 = 1'b1;
        fa = exp_frame(8'h5A, lc_wlen, 1'b1, 1'b0, 1'b0);
        la = exp_len(lc_wlen, 1'b1, 1'b1);
        tick = 1'b0;
        send(8'h5A);
        @(negedge clk);
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            chk("R8", "start bit held without ticks", int'(txd), 0);
        end
        chk("R8", "not empty while stalled", int'(tx_empty), 0);
        tick = 1'b1;
        check_frame(fa, la, 0, 8, 1'b1, "R8");

        // R11: settings changed mid-frame do not alter it
        lc_wlen = 2'b00; lc_par_en = 1'b1; lc_even = 1'b0; lc_sticky = 1'b0; lc_stop2 = 1'b1;
        fa = exp_frame(8'h13, 2'b00, 1'b1, 1'b0, 1'b0);
        la = exp_len(2'b00, 1'b1, 1'b1);
        send(8'h13);
        @(negedge clk);
        lc_wlen = 2'b11; lc_par_en = 1'b0; lc_even = 1'b1; lc_sticky = 1'b1;
        chk("R11", "ready after load", int'(in_ready), 1);
        lc_stop2 = 1'b1;
        check_frame(fa, la, 0, 8, 1'b1, "R11");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule